// File: doc/BRIEF.md
# Configurable PLD Output Macrocell Bank

This block is the output stage of a small programmable logic array: a bank of cells, eight by default, each of which sits between one sum-of-products line from the AND-OR array and one I/O pad. Every cell takes its sum term, its own output-enable product term and the value seen on its pad. From these it forms three things: a pad output value, a tri-state enable for that pad, and a feedback bit that goes back into the AND array as an input literal.

Two bank-wide bits and two bits per cell set what each cell does. One global bit (`cfg_comb`) and the cell's mode bit (`cfg_mode[i]`) together pick one of four behaviours: a registered output on a rising-edge flip-flop, a combinational output that is always driven, a combinational output gated by a product term, or a pure input where the pad is never driven. The per-cell polarity bit (`cfg_pol[i]`) picks an active-high or active-low output.

An input-mode cell takes its feedback from the pad of the next cell up. The two end cells have no such neighbour, so they use the global output-enable pin and the clock pin instead. The end cells also steer their feedback multiplexer from the second global bit (`cfg_edge`) rather than from `cfg_comb`. The interface has no data stream, so every pin is a plain level. There is no handshake.

Top module: `pld_mc_bank`

## Requirements
- R1: For cell i, the code {cfg_comb, cfg_mode[i]} selects the mode: 2'b00 registered output, 2'b01 combinational always enabled, 2'b10 combinational enabled by a product term, 2'b11 dedicated input.
- R2: In registered mode, pad_oe[i] equals oe_pin.
- R3: In mode 2'b01, pad_oe[i] is 1. In mode 2'b10, pad_oe[i] equals en_term[i].
- R4: In dedicated input mode, pad_oe[i] is 0.
- R5: The polarity-adjusted term is sum_term[i] when cfg_pol[i] is 1 and the inverse of sum_term[i] when cfg_pol[i] is 0. In every mode except registered mode, pad_out[i] equals this term with no clock delay.
- R6: Each cell's flip-flop loads the polarity-adjusted term on every rising clk edge and is cleared by rst_n low. In registered mode, pad_out[i] shows the flip-flop.
- R7: When a cell's feedback code is 2'b00, fb[i] is the inverse of the flip-flop. In a registered-mode cell this makes fb[i] equal to the inverse of pad_out[i].
- R8: When a cell's feedback code is 2'b01 or 2'b10, fb[i] equals pad_in[i], the cell's own pad.
- R9: When a middle cell's feedback code is 2'b11, fb[i] equals pad_in[i+1], the pad of the next cell up.
- R10: When the feedback code is 2'b11, cell 0 feeds back oe_pin and the last cell feeds back the level of clk.
- R11: The feedback code is {cfg_comb, cfg_mode[i]} for middle cells and {cfg_edge, cfg_mode[i]} for the two end cells. cfg_edge has no effect on middle cells.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock. The last cell also feeds it back as an input. |
| rst_n | input | 1 | Asynchronous active-low clear of all cell flip-flops |
| oe_pin | input | 1 | Global output enable for registered cells. Cell 0 also feeds it back as an input. |
| cfg_comb | input | 1 | Global mode bit for all cells. It is also the feedback select bit for middle cells. |
| cfg_edge | input | 1 | Feedback select bit for the two end cells |
| cfg_mode | input | N_CELLS | Per-cell mode bit |
| cfg_pol | input | N_CELLS | Per-cell polarity: 1 active high, 0 active low |
| sum_term | input | N_CELLS | Sum-of-products line for each cell |
| en_term | input | N_CELLS | Output-enable product term for each cell |
| pad_in | input | N_CELLS | Level seen on each I/O pad |
| pad_out | output | N_CELLS | Value each cell drives toward its pad |
| pad_oe | output | N_CELLS | Tri-state enable of each pad driver |
| fb | output | N_CELLS | Feedback bit returned to the AND array |

## Verification
A wrong mode decode shows at pad_oe in the same cycle, because every enable source is combinational. A bad polarity or output-select path shows at pad_out at once in the combinational modes. In registered mode, a bad capture shows at pad_out one rising edge later. A stale or wrong flip-flop also appears in fb as the inverse of pad_out. A mis-wired feedback source shows only once the matching code is selected. That makes every feedback code in both end cells and in a middle cell worth driving with distinct pad, oe_pin and clock levels.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;

  // Mode code {global select, cell select}
  typedef enum logic [1:0] {
    MC_REG     = 2'b00,
    MC_COMB_ON = 2'b01,
    MC_COMB_PT = 2'b10,
    MC_INPUT   = 2'b11
  } mc_mode_e;

  typedef enum logic [1:0] {
    EN_GLOBAL = 2'd0,
    EN_ALWAYS = 2'd1,
    EN_TERM   = 2'd2,
    EN_NEVER  = 2'd3
  } en_src_e;

  typedef enum logic [1:0] {
    FB_REG_N  = 2'd0,
    FB_OWN    = 2'd1,
    FB_ALT    = 2'd2
  } fb_src_e;

  typedef struct packed {
    en_src_e en_src;
    logic    out_reg;
    fb_src_e fb_src;
  } mc_ctl_t;

endpackage

// File: rtl/mc_ctl_decode.sv
module mc_ctl_decode
  import pld_mc_pkg::*;
(
  input  logic    glob_sel,
  input  logic    fb_glob_sel,
  input  logic    cell_sel,
  output mc_ctl_t ctl
);

  mc_mode_e mode;
  mc_mode_e fb_code;

  assign mode    = mc_mode_e'({glob_sel, cell_sel});
  assign fb_code = mc_mode_e'({fb_glob_sel, cell_sel});

  always_comb begin
    ctl = '{en_src: EN_NEVER, out_reg: 1'b0, fb_src: FB_OWN};
    unique case (mode)
      MC_REG:     begin ctl.en_src = EN_GLOBAL; ctl.out_reg = 1'b1; end
      MC_COMB_ON: ctl.en_src = EN_ALWAYS;
      MC_COMB_PT: ctl.en_src = EN_TERM;
      MC_INPUT:   ctl.en_src = EN_NEVER;
      default:    ctl.en_src = EN_NEVER;
    endcase
    unique case (fb_code)
      MC_REG:   ctl.fb_src = FB_REG_N;
      MC_INPUT: ctl.fb_src = FB_ALT;
      default:  ctl.fb_src = FB_OWN;
    endcase
  end

endmodule

// File: rtl/mc_cell.sv
module mc_cell
  import pld_mc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    oe_pin,
  input  mc_ctl_t ctl,
  input  logic    pol,
  input  logic    sum,
  input  logic    en_term,
  input  logic    pad_in,
  input  logic    alt_in,
  output logic    pad_out,
  output logic    pad_oe,
  output logic    fb
);

  logic d_term;
  logic q;

  assign d_term = pol ? sum : ~sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d_term;
  end

  assign pad_out = ctl.out_reg ? q : d_term;

  always_comb begin
    unique case (ctl.en_src)
      EN_GLOBAL: pad_oe = oe_pin;
      EN_ALWAYS: pad_oe = 1'b1;
      EN_TERM:   pad_oe = en_term;
      default:   pad_oe = 1'b0;
    endcase
  end

  always_comb begin
    unique case (ctl.fb_src)
      FB_REG_N: fb = ~q;
      FB_ALT:   fb = alt_in;
      default:  fb = pad_in;
    endcase
  end

endmodule

// File: rtl/pld_mc_bank.sv
module pld_mc_bank
  import pld_mc_pkg::*;
#(
  parameter int N_CELLS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               oe_pin,
  input  logic               cfg_comb,
  input  logic               cfg_edge,
  input  logic [N_CELLS-1:0] cfg_mode,
  input  logic [N_CELLS-1:0] cfg_pol,
  input  logic [N_CELLS-1:0] sum_term,
  input  logic [N_CELLS-1:0] en_term,
  input  logic [N_CELLS-1:0] pad_in,
  output logic [N_CELLS-1:0] pad_out,
  output logic [N_CELLS-1:0] pad_oe,
  output logic [N_CELLS-1:0] fb
);

  localparam int LAST = N_CELLS - 1;

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    logic    alt_src;
    logic    fb_glob;
    mc_ctl_t ctl;

    if (i == 0) begin : g_low_end
      assign alt_src = oe_pin;
      assign fb_glob = cfg_edge;
    end else if (i == LAST) begin : g_high_end
      assign alt_src = clk;
      assign fb_glob = cfg_edge;
    end else begin : g_mid
      assign alt_src = pad_in[i+1];
      assign fb_glob = cfg_comb;
    end

    mc_ctl_decode u_dec (
      .glob_sel    (cfg_comb),
      .fb_glob_sel (fb_glob),
      .cell_sel    (cfg_mode[i]),
      .ctl         (ctl)
    );

    mc_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .oe_pin  (oe_pin),
      .ctl     (ctl),
      .pol     (cfg_pol[i]),
      .sum     (sum_term[i]),
      .en_term (en_term[i]),
      .pad_in  (pad_in[i]),
      .alt_in  (alt_src),
      .pad_out (pad_out[i]),
      .pad_oe  (pad_oe[i]),
      .fb      (fb[i])
    );
  end

endmodule

// File: rtl/pld_mc_bank_chk.sv
module pld_mc_bank_chk #(
  parameter int N_CELLS = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               oe_pin,
  input logic               cfg_comb,
  input logic [N_CELLS-1:0] cfg_mode,
  input logic [N_CELLS-1:0] cfg_pol,
  input logic [N_CELLS-1:0] sum_term,
  input logic [N_CELLS-1:0] en_term,
  input logic [N_CELLS-1:0] pad_in,
  input logic [N_CELLS-1:0] pad_out,
  input logic [N_CELLS-1:0] pad_oe,
  input logic [N_CELLS-1:0] fb
);

  for (genvar i = 0; i < N_CELLS; i++) begin : g_chk
    // R2
    reg_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_comb && !cfg_mode[i]) |-> (pad_oe[i] == oe_pin));
    // R3
    term_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_comb && !cfg_mode[i]) |-> (pad_oe[i] == en_term[i]));
    // R4
    input_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_comb && cfg_mode[i]) |-> !pad_oe[i]);
    // R5
    comb_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_comb || cfg_mode[i]) |-> (pad_out[i] == (sum_term[i] ~^ cfg_pol[i])));
    // R6
    reg_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !cfg_comb && !cfg_mode[i])
        |-> (pad_out[i] == $past(sum_term[i] ~^ cfg_pol[i])));
    if (i > 0 && i < N_CELLS - 1) begin : g_mid
      // R7
      reg_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_comb && !cfg_mode[i]) |-> (fb[i] == !pad_out[i]));
      // R9
      nbr_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_comb && cfg_mode[i]) |-> (fb[i] == pad_in[i+1]));
    end
  end

endmodule

bind pld_mc_bank pld_mc_bank_chk #(.N_CELLS(N_CELLS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .oe_pin   (oe_pin),
  .cfg_comb (cfg_comb),
  .cfg_mode (cfg_mode),
  .cfg_pol  (cfg_pol),
  .sum_term (sum_term),
  .en_term  (en_term),
  .pad_in   (pad_in),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe),
  .fb       (fb)
);

// File: tb/pld_mc_bank_test.sv
`timescale 1ns/1ps
module pld_mc_bank_test;

  localparam int NC = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          oe_pin = 1'b1;
  logic          cfg_comb = 1'b0;
  logic          cfg_edge = 1'b0;
  logic [NC-1:0] cfg_mode = '0;
  logic [NC-1:0] cfg_pol = '1;
  logic [NC-1:0] sum_term = '0;
  logic [NC-1:0] en_term = '0;
  logic [NC-1:0] pad_in = '0;
  logic [NC-1:0] pad_out, pad_oe, fb;

  int errors = 0;
  int checks = 0;
  logic [NC-1:0] q_m = '0;

  typedef struct packed {
    logic [NC-1:0] val;
    logic [NC-1:0] oe;
    logic [NC-1:0] fbk;
  } exp_t;

  exp_t exp_q[$];
  event item_ev;

  always #10 clk = ~clk;

  pld_mc_bank #(.N_CELLS(NC)) uut (
    .clk(clk), .rst_n(rst_n), .oe_pin(oe_pin), .cfg_comb(cfg_comb),
    .cfg_edge(cfg_edge), .cfg_mode(cfg_mode), .cfg_pol(cfg_pol),
    .sum_term(sum_term), .en_term(en_term), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .fb(fb)
  );

  // Reference from the requirements (R1 mode table, R11 feedback code)
  function automatic exp_t model(logic clkv);
    exp_t e;
    for (int i = 0; i < NC; i++) begin
      logic d;
      logic fg;
      logic alt;
      d = cfg_pol[i] ? sum_term[i] : ~sum_term[i];
      case ({cfg_comb, cfg_mode[i]})
        2'b00:   begin e.val[i] = q_m[i]; e.oe[i] = oe_pin;     end
        2'b01:   begin e.val[i] = d;      e.oe[i] = 1'b1;       end
        2'b10:   begin e.val[i] = d;      e.oe[i] = en_term[i]; end
        default: begin e.val[i] = d;      e.oe[i] = 1'b0;       end
      endcase
      fg  = (i == 0 || i == NC-1) ? cfg_edge : cfg_comb;
      alt = (i == 0) ? oe_pin : (i == NC-1) ? clkv : pad_in[i+1];
      case ({fg, cfg_mode[i]})
        2'b00:   e.fbk[i] = ~q_m[i];
        2'b11:   e.fbk[i] = alt;
        default: e.fbk[i] = pad_in[i];
      endcase
    end
    return e;
  endfunction

  task automatic cmp(string tag, logic [NC-1:0] act, logic [NC-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b (comb=%b edge=%b mode=%b)",
               tag, act, exp, cfg_comb, cfg_edge, cfg_mode);
    end
  endtask

  // Driver: sets inputs, advances one rising edge, queues the expectation
  task automatic apply(logic gc, logic ge, logic [NC-1:0] md, logic [NC-1:0] pl,
                       logic [NC-1:0] sm, logic [NC-1:0] en, logic [NC-1:0] pi,
                       logic oe);
    @(negedge clk);
    cfg_comb = gc; cfg_edge = ge; cfg_mode = md; cfg_pol = pl;
    sum_term = sm; en_term = en; pad_in = pi; oe_pin = oe;
    @(posedge clk);
    for (int i = 0; i < NC; i++) q_m[i] = pl[i] ? sm[i] : ~sm[i];
    exp_q.push_back(model(1'b1));
    -> item_ev;
  endtask

  // Monitor: samples 1 ns after the edge and compares
  initial begin
    forever begin
      @(item_ev);
      #1;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        cmp("R1/R5/R6 pad_out", pad_out, e.val);
        cmp("R2/R3/R4 pad_oe", pad_oe, e.oe);
        cmp("R7/R8/R9/R10/R11 fb", fb, e.fbk);
      end
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [NC-1:0] modes [4];
    modes[0] = 8'h00; modes[1] = 8'hFF; modes[2] = 8'hA5; modes[3] = 8'h5A;

    // Reset state: R6 flip-flops clear, registered cells show 0, fb = 1
    repeat (3) @(posedge clk);
    #1;
    cmp("R6 reset pad_out", pad_out, 8'h00);
    cmp("R2 reset pad_oe", pad_oe, 8'hFF);
    cmp("R7 reset fb", fb, 8'hFF);
    @(negedge clk);
    rst_n = 1'b1;
    q_m = '0;

    // Every global code, end-cell select and mode pattern
    for (int gc = 0; gc < 2; gc++)
      for (int ge = 0; ge < 2; ge++)
        for (int m = 0; m < 4; m++)
          for (int k = 0; k < 3; k++) begin
            logic [7:0] seed;
            seed = 8'(k * 53 + m * 29 + gc * 11 + ge * 7);
            apply(gc[0], ge[0], modes[m], seed ^ 8'h3C, seed, ~seed + 8'h17,
                  {seed[3:0], seed[7:4]}, k[0]);
          end

    // R11: cfg_edge toggled, middle cells unaffected; end cells switch source
    apply(1'b0, 1'b1, 8'hFF, 8'hFF, 8'h0F, 8'h00, 8'h96, 1'b0);
    apply(1'b1, 1'b0, 8'hFF, 8'h00, 8'hF0, 8'hFF, 8'h69, 1'b1);
    // R10: oe_pin as cell 0 input, both levels
    apply(1'b1, 1'b1, 8'h81, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b0);
    apply(1'b1, 1'b1, 8'h81, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b1);
    // R6: registered mode follows data through consecutive edges
    apply(1'b0, 1'b0, 8'h00, 8'hFF, 8'hAA, 8'h00, 8'h00, 1'b1);
    apply(1'b0, 1'b0, 8'h00, 8'h0F, 8'h55, 8'h00, 8'h00, 1'b0);

    // R10: last cell feeds back the clock level, low phase too
    @(negedge clk);
    cfg_comb = 1'b1; cfg_edge = 1'b1; cfg_mode = 8'h80;
    #1;
    cmp("R10 fb clk low", {7'b0, fb[NC-1]}, 8'h00);
    @(posedge clk);
    #1;
    cmp("R10 fb clk high", {7'b0, fb[NC-1]}, 8'h01);

    #5;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule